// File: doc/BRIEF.md
# Tower Data Link Framer with Error Correction

This block moves one bunch crossing's worth of calorimeter tower data, 48 one-byte channels, across 16 byte-wide serial lanes. Each lane carries three channel bytes and one check byte per frame. The four bytes of a frame leave on four consecutive cycles of a byte clock that runs at four times the frame rate. The check byte holds an extended Hamming code over the 24 data bits of the lane. The lane bytes, together with a per-byte control-character flag, are meant for a downstream 8B/10B encoder. When no frame is offered, the transmitter sends an idle frame that opens with a comma control character, so that the far end can find frame boundaries.

The receive half takes the same kind of lane bytes after decoding. It aligns to the comma on lane 0 and rebuilds each lane's three data bytes. It corrects any single flipped bit, flags double errors, and presents the 48 channels with one corrected flag and one uncorrectable flag per lane.

On the transmit side the input is a valid/ready stream. Ready rises for exactly one cycle in every four, in the last byte slot of the current frame. A frame is taken only when valid and ready are high together. Valid may be held high for as long as needed and does not have to wait for ready. The data must stay stable until it is accepted. The receive output has no ready, because a serial link cannot be paused. Each decoded frame appears as a single-cycle valid pulse.

Top module: `tower_link_framer`

## Requirements
- R1: `in_ready` is high for exactly one cycle out of every four byte-clock cycles. It is high in every cycle of reset, and its high cycles repeat every fourth cycle after reset is released.
- R2: After a frame is accepted on a clock edge, lane k outputs channel 3k, channel 3k+1, channel 3k+2 and then its check byte on the four following cycles. Channel c occupies `in_data[8c+7:8c]`. All `lane_tx_k` bits are 0 during these four cycles.
- R3: A lane's 24-bit word has channel 3k in bits 7:0, channel 3k+1 in bits 15:8 and channel 3k+2 in bits 23:16. Word bit j sits at the j-th position, counting upward, among codeword positions 1 to 29 that are not powers of two. Check bits 4:0 equal the XOR of the positions of all set word bits. Check bit 5 makes the parity of the 24 word bits plus check bits 5:0 even. Check bits 7:6 are 0.
- R4: If no frame is accepted in a ready cycle, the next four cycles carry an idle frame. Its first byte is 0xBC with `lane_tx_k` = 1 on every lane, and its other three bytes are 0x00 with `lane_tx_k` = 0.
- R5: The receiver takes a byte on lane 0 with its control flag set and value 0xBC as frame slot 0. It produces no output before the first such comma, and no output for a frame in which any lane's control flag was set.
- R6: For a frame received without errors, `out_valid` pulses for one cycle, one cycle after the check-byte slot. `out_data` then carries all 48 channels in the input layout, and both error flags are 0.
- R7: A single flipped bit in any of the 24 word bits or check bits 5:0 of a lane is corrected. That lane's `out_corr` is 1 and its `out_uncorr` is 0.
- R8: Two flipped bits among the 30 protected bits of a lane set that lane's `out_uncorr` to 1 and its `out_corr` to 0. The lane's data is passed on as received.
- R9: When `out_valid` is 0, all error flags are 0. No lane ever has both of its flags set.
- R10: Check bits 7:6 are ignored by the receiver. Flipping them changes neither the data nor the flags.
- R11: In reset, the lane outputs are 0x00 with all control flags 0, `out_valid` is 0, and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, four cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame of channel bytes is offered |
| in_ready | output | 1 | A frame can be taken this cycle |
| in_data | input | 384 | 48 channel bytes, channel c in bits 8c+7:8c |
| lane_tx_data | output | 128 | Transmit byte per lane, lane k in bits 8k+7:8k |
| lane_tx_k | output | 16 | Transmit control-character flag per lane |
| lane_rx_data | input | 128 | Receive byte per lane |
| lane_rx_k | input | 16 | Receive control-character flag per lane |
| out_valid | output | 1 | Single-cycle pulse marking a decoded frame |
| out_data | output | 384 | 48 corrected channel bytes |
| out_corr | output | 16 | Per-lane flag: a single error was corrected |
| out_uncorr | output | 16 | Per-lane flag: an uncorrectable error was found |

## Verification
The assertions assume that `in_valid` is low during reset, so that no handshake is seen before the frame counter starts. On the receive side they assume only what the design itself produces. The bench drives the receive lanes from the transmit lanes through an error mask that it applies in chosen byte slots. It sends one frame before any comma to cover the unlocked case, and lets idle frames pass between data frames so that realignment is exercised. The random error patterns are limited to none, one bit or two distinct bits among the 30 protected bits, or a single spare-bit flip per lane. Within those bounds the code's behaviour is fully specified.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
  localparam int LANE_CH = 3;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = LANE_CH * BYTE_W;
  localparam int SLOTS   = 4;
  localparam int FRAME_W = SLOTS * BYTE_W;
  localparam int CW_TOP  = 29;
  localparam int SYN_W   = 5;
  localparam logic [BYTE_W-1:0] COMMA_CHAR = 8'hBC;

  typedef logic [1:0] slot_t;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // place data bits on the non-power-of-two codeword positions
  function automatic logic [CW_TOP:1] spread(input logic [WORD_W-1:0] d);
    logic [CW_TOP:1] cw;
    logic [4:0] j;
    cw = '0;
    j  = '0;
    for (int p = 1; p <= CW_TOP; p++) begin
      if (!is_pow2(p)) begin
        cw[p] = d[j];
        j = j + 5'd1;
      end
    end
    return cw;
  endfunction

  function automatic logic [WORD_W-1:0] gather(input logic [CW_TOP:1] cw);
    logic [WORD_W-1:0] d;
    logic [4:0] j;
    d = '0;
    j = '0;
    for (int p = 1; p <= CW_TOP; p++) begin
      if (!is_pow2(p)) begin
        d[j] = cw[p];
        j = j + 5'd1;
      end
    end
    return d;
  endfunction

  function automatic logic [SYN_W-1:0] pos_xor(input logic [CW_TOP:1] cw);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CW_TOP; p++) begin
      if (cw[p]) s = s ^ SYN_W'(p);
    end
    return s;
  endfunction

  function automatic logic [BYTE_W-1:0] make_check(input logic [WORD_W-1:0] d);
    logic [BYTE_W-1:0] c;
    c = '0;
    c[SYN_W-1:0] = pos_xor(spread(d));
    c[SYN_W] = (^d) ^ (^c[SYN_W-1:0]);
    return c;
  endfunction
endpackage

// File: rtl/tlf_tx_framer.sv
module tlf_tx_framer
  import tlf_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [LANES*WORD_W-1:0]      in_data,
  output logic [LANES*BYTE_W-1:0]      lane_data,
  output logic [LANES-1:0]             lane_k
);
  slot_t slot_q;
  slot_t slot_n;
  logic  take;
  logic  hold_is_data;

  assign in_ready = (slot_q == slot_t'(SLOTS - 1));
  assign take     = in_valid && in_ready;
  assign slot_n   = slot_q + slot_t'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q       <= slot_t'(SLOTS - 1);
      hold_is_data <= 1'b0;
    end else begin
      slot_q <= slot_n;
      if (take)          hold_is_data <= 1'b1;
      else if (in_ready) hold_is_data <= 1'b0;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0]  word;
    logic [FRAME_W-1:0] fresh;
    logic [FRAME_W-1:0] hold_q;
    logic [FRAME_W-1:0] src;
    logic               send_data;
    logic [BYTE_W-1:0]  nxt_byte;
    logic               nxt_k;
    logic [BYTE_W-1:0]  byte_q;
    logic               k_q;

    assign word  = in_data[l*WORD_W +: WORD_W];
    assign fresh = {make_check(word), word};
    assign src   = take ? fresh : hold_q;

    always_comb begin
      send_data = take || ((slot_n != slot_t'(0)) && hold_is_data);
      nxt_k     = 1'b0;
      if (send_data)                nxt_byte = src[{slot_n, 3'b000} +: BYTE_W];
      else if (slot_n == slot_t'(0)) begin
        nxt_byte = COMMA_CHAR;
        nxt_k    = 1'b1;
      end else                      nxt_byte = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q <= '0;
        byte_q <= '0;
        k_q    <= 1'b0;
      end else begin
        if (take) hold_q <= fresh;
        byte_q <= nxt_byte;
        k_q    <= nxt_k;
      end
    end

    assign lane_data[l*BYTE_W +: BYTE_W] = byte_q;
    assign lane_k[l] = k_q;
  end
endmodule

// File: rtl/tlf_ecc_decoder.sv
module tlf_ecc_decoder
  import tlf_pkg::*;
(
  input  logic [WORD_W-1:0] rx_word,
  input  logic [SYN_W:0]    rx_check,
  output logic [WORD_W-1:0] fix_word,
  output logic              corr,
  output logic              uncorr
);
  logic [SYN_W-1:0] syn;
  logic             odd;
  logic [CW_TOP:1]  cw;

  assign syn = pos_xor(spread(rx_word)) ^ rx_check[SYN_W-1:0];
  assign odd = (^rx_word) ^ (^rx_check);

  always_comb begin
    cw     = spread(rx_word);
    corr   = 1'b0;
    uncorr = 1'b0;
    if (odd) begin
      if (int'(syn) > CW_TOP) begin
        uncorr = 1'b1;
      end else begin
        corr = 1'b1;
        if (syn != '0) cw[syn] = ~cw[syn];
      end
    end else if (syn != '0) begin
      uncorr = 1'b1;
    end
    fix_word = gather(cw);
  end
endmodule

// File: rtl/tlf_rx_deframer.sv
module tlf_rx_deframer
  import tlf_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES*BYTE_W-1:0]   lane_data,
  input  logic [LANES-1:0]          lane_k,
  output logic                      out_valid,
  output logic [LANES*WORD_W-1:0]   out_data,
  output logic [LANES-1:0]          out_corr,
  output logic [LANES-1:0]          out_uncorr
);
  slot_t slot_q;
  slot_t pos;
  logic  comma0;
  logic  locked_q;
  logic  clean_q;
  logic  any_k;
  logic  emit;

  assign comma0 = lane_k[0] && (lane_data[BYTE_W-1:0] == COMMA_CHAR);
  assign pos    = comma0 ? slot_t'(0) : slot_q;
  assign any_k  = |lane_k;
  assign emit   = (pos == slot_t'(SLOTS - 1)) && locked_q && clean_q && !any_k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q    <= '0;
      locked_q  <= 1'b0;
      clean_q   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      slot_q    <= pos + slot_t'(1);
      locked_q  <= locked_q || comma0;
      clean_q   <= (pos == slot_t'(0)) ? !any_k : (clean_q && !any_k);
      out_valid <= emit;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] fix;
    logic              c_err;
    logic              u_err;
    logic [WORD_W-1:0] data_q;
    logic              corr_q;
    logic              uncorr_q;
    logic [BYTE_W-1:0] in_byte;

    assign in_byte = lane_data[l*BYTE_W +: BYTE_W];

    tlf_ecc_decoder u_dec (
      .rx_word (word_q),
      .rx_check(in_byte[SYN_W:0]),
      .fix_word(fix),
      .corr    (c_err),
      .uncorr  (u_err)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q   <= '0;
        data_q   <= '0;
        corr_q   <= 1'b0;
        uncorr_q <= 1'b0;
      end else begin
        if (pos != slot_t'(SLOTS - 1)) word_q[{pos, 3'b000} +: BYTE_W] <= in_byte;
        if (emit) data_q <= fix;
        corr_q   <= emit && c_err;
        uncorr_q <= emit && u_err;
      end
    end

    assign out_data[l*WORD_W +: WORD_W] = data_q;
    assign out_corr[l]   = corr_q;
    assign out_uncorr[l] = uncorr_q;
  end
endmodule

// File: rtl/tower_link_framer.sv
module tower_link_framer
  import tlf_pkg::*;
#(
  parameter int LANES = 16,
  localparam int NCH  = LANES * LANE_CH,
  localparam int CH_W = NCH * BYTE_W,
  localparam int LN_W = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CH_W-1:0]  in_data,
  output logic [LN_W-1:0]  lane_tx_data,
  output logic [LANES-1:0] lane_tx_k,
  input  logic [LN_W-1:0]  lane_rx_data,
  input  logic [LANES-1:0] lane_rx_k,
  output logic             out_valid,
  output logic [CH_W-1:0]  out_data,
  output logic [LANES-1:0] out_corr,
  output logic [LANES-1:0] out_uncorr
);
  tlf_tx_framer #(.LANES(LANES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .lane_data(lane_tx_data),
    .lane_k   (lane_tx_k)
  );

  tlf_rx_deframer #(.LANES(LANES)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_data (lane_rx_data),
    .lane_k    (lane_rx_k),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_corr  (out_corr),
    .out_uncorr(out_uncorr)
  );
endmodule

// File: rtl/tower_link_framer_chk.sv
module tower_link_framer_chk
  import tlf_pkg::*;
#(
  parameter int LANES = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [LANES*BYTE_W-1:0] lane_tx_data,
  input logic [LANES-1:0]        lane_tx_k,
  input logic                    out_valid,
  input logic [LANES-1:0]        out_corr,
  input logic [LANES-1:0]        out_uncorr
);
  logic [LANES-1:0] spare_set;
  logic [LANES-1:0] is_comma;

  for (genvar l = 0; l < LANES; l++) begin : g_l
    assign spare_set[l] = |lane_tx_data[l*BYTE_W+6 +: 2];
    assign is_comma[l]  = lane_tx_data[l*BYTE_W +: BYTE_W] == COMMA_CHAR;
  end

  a_r1_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  a_r2_data_no_k: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (lane_tx_k == '0));

  a_r3_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready, 4) |-> (spare_set == '0 && lane_tx_k == '0));

  a_r4_idle_comma: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (lane_tx_k == '1 && is_comma == '1));

  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r9_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_corr == '0 && out_uncorr == '0));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (out_corr & out_uncorr) == '0);
endmodule

bind tower_link_framer tower_link_framer_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .lane_tx_data(lane_tx_data),
  .lane_tx_k   (lane_tx_k),
  .out_valid   (out_valid),
  .out_corr    (out_corr),
  .out_uncorr  (out_uncorr)
);

// File: tb/sim_tower_link_framer.sv
`timescale 1ns/1ps
module sim_tower_link_framer;
  localparam int L = 16;
  localparam int NB = L * 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NB*8-1:0] in_data = '0;
  logic [L*8-1:0] lane_tx_data;
  logic [L-1:0] lane_tx_k;
  logic [L*8-1:0] inj = '0;
  logic [L*8-1:0] lane_rx_data;
  logic out_valid;
  logic [NB*8-1:0] out_data;
  logic [L-1:0] out_corr, out_uncorr;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [31:0] msk [L];
  int kind [L];

  always #2 clk = ~clk;
  assign lane_rx_data = lane_tx_data ^ inj;

  tower_link_framer #(.LANES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .lane_tx_data(lane_tx_data), .lane_tx_k(lane_tx_k),
    .lane_rx_data(lane_rx_data), .lane_rx_k(lane_tx_k), .out_valid(out_valid),
    .out_data(out_data), .out_corr(out_corr), .out_uncorr(out_uncorr)
  );

  function automatic bit bpow2(int v);
    return (v & (v - 1)) == 0;
  endfunction

  function automatic logic [7:0] exp_check(logic [23:0] w);
    int pos = 1;
    logic [7:0] c = '0;
    for (int j = 0; j < 24; j++) begin
      while (bpow2(pos)) pos++;
      if (w[j]) c[4:0] = c[4:0] ^ pos[4:0];
      pos++;
    end
    c[5] = (^w) ^ (^c[4:0]);
    return c;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_errs();
    for (int l = 0; l < L; l++) begin msk[l] = '0; kind[l] = 0; end
  endtask

  task automatic run_frame(logic [NB*8-1:0] d, bit expect_out);
    logic [31:0] word;
    logic [7:0] eb;
    bit txok;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    for (int s = 0; s < 4; s++) begin
      txok = 1;
      for (int l = 0; l < L; l++) begin
        word = {exp_check(d[l*24 +: 24]), d[l*24 +: 24]};
        eb = word[s*8 +: 8];
        inj[l*8 +: 8] = msk[l][s*8 +: 8];
        if (lane_tx_data[l*8 +: 8] !== eb || lane_tx_k[l] !== 1'b0) begin
          txok = 0;
          $display("FAIL R2/R3 lane %0d slot %0d actual=%0h expected=%0h", l, s,
                   lane_tx_data[l*8 +: 8], eb);
        end
      end
      nchk++;
      if (!txok) nerr++;
      @(negedge clk);
    end
    inj = '0;
    check(out_valid === expect_out, expect_out ? "R6 out_valid" : "R5 no output unlocked",
          64'(out_valid), 64'(expect_out));
    if (expect_out) begin
      for (int l = 0; l < L; l++) begin
        logic [23:0] ed;
        string tag;
        ed = d[l*24 +: 24] ^ ((kind[l] == 2) ? msk[l][23:0] : 24'h0);
        tag = (kind[l] == 1) ? "R7" : (kind[l] == 2) ? "R8" : (kind[l] == 3) ? "R10" : "R6";
        check(out_data[l*24 +: 24] === ed && out_corr[l] === (kind[l] == 1) &&
              out_uncorr[l] === (kind[l] == 2), tag,
              {38'h0, out_corr[l], out_uncorr[l], out_data[l*24 +: 24]},
              {38'h0, kind[l] == 1, kind[l] == 2, ed});
      end
    end
  endtask

  function automatic logic [NB*8-1:0] rand_data();
    logic [NB*8-1:0] d;
    for (int i = 0; i < NB; i++) d[i*8 +: 8] = 8'($urandom);
    return d;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    logic [NB*8-1:0] d;
    int seed_dummy;
    int cnt;
    seed_dummy = $urandom(32'd4711);
    clear_errs();
    repeat (3) @(negedge clk);
    // R11: reset values
    check(lane_tx_data === '0 && lane_tx_k === '0, "R11 lane reset", 64'(lane_tx_k), 64'h0);
    check(out_valid === 1'b0 && out_corr === '0 && out_uncorr === '0, "R11 out reset",
          64'(out_valid), 64'h0);
    check(in_ready === 1'b1, "R1 ready in reset", 64'(in_ready), 64'h1);
    rst_n = 1'b1;

    // R5: frame before any comma gives no output
    run_frame(rand_data(), 1'b0);

    // R1: ready one cycle in four
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      if (in_ready) cnt++;
      @(negedge clk);
    end
    check(cnt == 2, "R1 ready rate", 64'(cnt), 64'd2);

    // R4/R5: idle frame content, no output
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    check(lane_tx_k === '1, "R4 idle k", 64'(lane_tx_k), 64'hffff);
    check(lane_tx_data === {L{8'hBC}}, "R4 idle comma", lane_tx_data[63:0], {8{8'hBC}});
    for (int s = 1; s < 4; s++) begin
      @(negedge clk);
      check(lane_tx_data === '0 && lane_tx_k === '0, "R4 idle fill", lane_tx_data[63:0], 64'h0);
      check(out_valid === 1'b0, "R5 idle no output", 64'(out_valid), 64'h0);
    end

    // R6: clean frames, fixed patterns
    run_frame('0, 1'b1);
    run_frame('1, 1'b1);
    for (int i = 0; i < NB; i++) d[i*8 +: 8] = 8'(i * 5 + 1);
    run_frame(d, 1'b1);

    // R7: single errors on word bits then on check bits
    for (int l = 0; l < L; l++) begin kind[l] = 1; msk[l] = 32'h1 << l; end
    run_frame(rand_data(), 1'b1);
    for (int l = 0; l < L; l++) begin kind[l] = 1; msk[l] = 32'h1 << (14 + l); end
    run_frame(rand_data(), 1'b1);

    // R8: double errors
    for (int l = 0; l < L; l++) begin
      kind[l] = 2;
      msk[l] = (32'h1 << l) | (32'h1 << (29 - (l % 5)));
    end
    run_frame(rand_data(), 1'b1);

    // R10: spare bits flipped
    for (int l = 0; l < L; l++) begin kind[l] = 3; msk[l] = (l % 2) ? 32'hC000_0000 : 32'h4000_0000; end
    run_frame(rand_data(), 1'b1);

    // random mix
    for (int f = 0; f < 60; f++) begin
      for (int l = 0; l < L; l++) begin
        int b1, b2;
        kind[l] = int'($urandom % 4);
        b1 = int'($urandom % 30);
        b2 = (b1 + 1 + int'($urandom % 29)) % 30;
        case (kind[l])
          1: msk[l] = 32'h1 << b1;
          2: msk[l] = (32'h1 << b1) | (32'h1 << b2);
          3: msk[l] = 32'h1 << (30 + int'($urandom % 2));
          default: msk[l] = '0;
        endcase
      end
      run_frame(rand_data(), 1'b1);
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule